// File: doc/BRIEF.md
# Register File with Stack Sequencer

This block holds sixteen 16-bit registers. Register 0 serves as the program counter and register 1 as the stack pointer. Two combinational read ports and one write port give general access. A one-bit advance input steps the program counter to the next instruction word.

A small sequencer carries out four stack operations through a single memory request channel: push, pop, subroutine call and subroutine return. The stack grows toward lower addresses, and the stack pointer always holds the byte address of the most recently stored word. Call and return use the same stack path as push and pop. The only difference is that the stored or loaded word is the program counter.

Each operation holds its memory request until the memory answers with ready. Registers change only on the ready cycle. A done pulse follows on the next cycle.

Top module: `regfile_stack`

## Requirements
- R1: After reset the program counter equals parameter RESET_PC and the stack pointer equals parameter RESET_SP, each with bit 0 cleared. Every other register reads 0, both memory strobes are low and op_done is low.
- R2: The program counter is always even: bit 0 is cleared on a port write to register 0, on a return load and on a call target load.
- R3: The stack pointer is always even: bit 0 is cleared on a port write to register 1.
- R4: pc_advance adds 2 to the program counter. A port write to register 0 in the same cycle takes precedence over the advance.
- R5: A push (op_kind 2'b00) writes op_operand to memory at address SP-2 and leaves SP at SP-2.
- R6: A pop (op_kind 2'b01) reads memory at address SP into register op_dest and leaves SP at SP+2. When op_dest is 1, SP still ends at SP+2.
- R7: A call (op_kind 2'b10) writes the program counter value held when the request was taken to address SP-2. It then sets SP to SP-2 and loads op_operand into the program counter.
- R8: A return (op_kind 2'b11) loads the program counter from memory at address SP and leaves SP at SP+2.
- R9: While a request waits for mem_ready, exactly one strobe stays high, the address stays fixed, and the program counter and stack pointer do not change.
- R10: op_done is high for exactly one cycle, the cycle after the one in which mem_ready completed a request.
- R11: When a stack update and a port write target the same register in the same cycle, the stack update wins.
- R12: op_valid is ignored while an operation is in progress.
- R13: Both read ports return the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_addr | input | 4 | Read port A register index |
| rd_a_data | output | 16 | Read port A data |
| rd_b_addr | input | 4 | Read port B register index |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | Port write enable |
| wr_addr | input | 4 | Port write register index |
| wr_data | input | 16 | Port write data |
| pc_advance | input | 1 | Step program counter by one word |
| op_valid | input | 1 | Stack operation request |
| op_kind | input | 2 | 00 push, 01 pop, 10 call, 11 return |
| op_operand | input | 16 | Push data or call target |
| op_dest | input | 4 | Pop destination register |
| mem_addr | output | 16 | Memory byte address of the word |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_ready | input | 1 | Memory completes the current request |
| pc | output | 16 | Current program counter |
| sp | output | 16 | Current stack pointer |
| op_done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the environment neither writes register 1 nor advances the program counter while a stack request is waiting. If it did, the held address and the stable stack pointer would legitimately move. The directed stimulus therefore asserts port writes and pc_advance only while the sequencer is idle, or in the ready cycle itself. In the ready cycle the override rule is the point under test. The memory model raises mem_ready only while a strobe is high, so every completion seen by the checker belongs to a real request.

// File: rtl/regfile_stack.sv
module regfile_stack #(
  parameter int DW = 16,
  parameter int AW = 4,
  parameter logic [DW-1:0] RESET_PC = 16'h4000,
  parameter logic [DW-1:0] RESET_SP = 16'h0200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a_addr,
  output logic [DW-1:0] rd_a_data,
  input  logic [AW-1:0] rd_b_addr,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          pc_advance,
  input  logic          op_valid,
  input  logic [1:0]    op_kind,
  input  logic [DW-1:0] op_operand,
  input  logic [AW-1:0] op_dest,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic          mem_ready,
  output logic [DW-1:0] pc,
  output logic [DW-1:0] sp,
  output logic          op_done
);
  localparam int NREG = 1 << AW;
  localparam logic [DW-1:0] EVEN = ~DW'(1);
  localparam logic [DW-1:0] STEP = DW'(2);
  localparam logic [1:0] K_PUSH = 2'd0, K_POP = 2'd1, K_CALL = 2'd2, K_RET = 2'd3;

  logic [DW-1:0] rf [NREG];
  logic          busy, done_q;
  logic [1:0]    kind_q;
  logic [DW-1:0] data_q, tgt_q;
  logic [AW-1:0] dest_q;
  logic          fin;

  assign pc        = rf[0];
  assign sp        = rf[1];
  assign rd_a_data = rf[rd_a_addr];
  assign rd_b_data = rf[rd_b_addr];
  assign mem_rd    = busy & kind_q[0];
  assign mem_wr    = busy & ~kind_q[0];
  assign mem_addr  = kind_q[0] ? sp : sp - STEP;
  assign mem_wdata = data_q;
  assign op_done   = done_q;
  assign fin       = busy & mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      rf[0]  <= RESET_PC & EVEN;
      rf[1]  <= RESET_SP & EVEN;
      busy   <= 1'b0;
      done_q <= 1'b0;
      kind_q <= K_PUSH;
      data_q <= '0;
      tgt_q  <= '0;
      dest_q <= '0;
    end else begin
      done_q <= fin;
      if (!busy && op_valid) begin
        busy   <= 1'b1;
        kind_q <= op_kind;
        data_q <= (op_kind == K_CALL) ? rf[0] : op_operand;
        tgt_q  <= op_operand;
        dest_q <= op_dest;
      end
      if (fin) busy <= 1'b0;
      if (pc_advance) rf[0] <= rf[0] + STEP;
      if (wr_en) rf[wr_addr] <= (wr_addr < AW'(2)) ? (wr_data & EVEN) : wr_data;
      if (fin) begin
        case (kind_q)
          K_PUSH: rf[1] <= sp - STEP;
          K_CALL: begin
            rf[1] <= sp - STEP;
            rf[0] <= tgt_q & EVEN;
          end
          K_POP: begin
            rf[dest_q] <= (dest_q < AW'(2)) ? (mem_rdata & EVEN) : mem_rdata;
            rf[1]      <= sp + STEP;
          end
          default: begin
            rf[0] <= mem_rdata & EVEN;
            rf[1] <= sp + STEP;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/regfile_stack_chk.sv
module regfile_stack_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] pc,
  input logic [DW-1:0] sp,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          mem_ready,
  input logic [DW-1:0] mem_addr,
  input logic          op_done
);
  a_r2_pc_even: assert property (@(posedge clk) disable iff (!rst_n) pc[0] == 1'b0);
  a_r3_sp_even: assert property (@(posedge clk) disable iff (!rst_n) sp[0] == 1'b0);
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) && !mem_ready |=>
      (mem_rd == $past(mem_rd)) && (mem_wr == $past(mem_wr)) && $stable(mem_addr) && $stable(sp));
  a_r5_push_sp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && mem_ready |=> sp == $past(sp) - DW'(2));
  a_r6_pop_sp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && mem_ready |=> sp == $past(sp) + DW'(2));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) op_done |=> !op_done);
  a_r10_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> $past(mem_ready && (mem_rd || mem_wr)));
endmodule

bind regfile_stack regfile_stack_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc(pc), .sp(sp), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .op_done(op_done)
);

// File: tb/regfile_stack_tb.sv
module regfile_stack_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0, op_dest = '0;
  logic [15:0] rd_a_data, rd_b_data, wr_data = '0, op_operand = '0;
  logic        wr_en = 1'b0, pc_advance = 1'b0, op_valid = 1'b0, mem_ready = 1'b0;
  logic [1:0]  op_kind = '0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, pc, sp;
  logic        mem_rd, mem_wr, op_done;
  logic [15:0] mem [256];
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regfile_stack u_dut (
    .clk(clk), .rst_n(rst_n), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pc_advance(pc_advance), .op_valid(op_valid), .op_kind(op_kind),
    .op_operand(op_operand), .op_dest(op_dest), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ready(mem_ready),
    .pc(pc), .sp(sp), .op_done(op_done)
  );

  assign mem_rdata = mem[mem_addr[8:1]];
  always @(posedge clk) if (mem_wr && mem_ready) mem[mem_addr[8:1]] <= mem_wdata;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic port_write(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_op(input logic [1:0] kind, input logic [15:0] opnd, input logic [3:0] dest,
                       input int waits, input logic [15:0] exp_addr,
                       input bit clash, input logic [3:0] clash_reg, input bit inject);
    logic [15:0] pc0, sp0;
    pc0 = pc; sp0 = sp;
    op_valid = 1'b1; op_kind = kind; op_operand = opnd; op_dest = dest;
    @(negedge clk);
    op_valid = 1'b0;
    for (int i = 0; i < waits; i++) begin
      chk("R9 strobe", {14'd0, mem_rd, mem_wr}, kind[0] ? 16'd2 : 16'd1);
      chk("R9 addr", mem_addr, exp_addr);
      chk("R9 sp held", sp, sp0);
      chk("R9 pc held", pc, pc0);
      if (inject && i == 0) begin op_valid = 1'b1; op_kind = 2'd3; end
      @(negedge clk);
      op_valid = 1'b0;
    end
    chk("R9 addr at ready", mem_addr, exp_addr);
    mem_ready = 1'b1;
    if (clash) begin wr_en = 1'b1; wr_addr = clash_reg; wr_data = 16'h0100; end
    @(negedge clk);
    mem_ready = 1'b0; wr_en = 1'b0;
    chk("R10 done high", {15'd0, op_done}, 16'd1);
  endtask

  task automatic after_done;
    @(negedge clk);
    chk("R10 done low", {15'd0, op_done}, 16'd0);
    chk("R12 idle strobes", {14'd0, mem_rd, mem_wr}, 16'd0);
  endtask

  task automatic t_reset;
    rd_a_addr = 4'd5; rd_b_addr = 4'd15;
    #1;
    chk("R1 pc", pc, 16'h4000);
    chk("R1 sp", sp, 16'h0200);
    chk("R1 r5", rd_a_data, 16'h0000);
    chk("R1 r15", rd_b_data, 16'h0000);
    chk("R1 strobes", {14'd0, mem_rd, mem_wr}, 16'd0);
    chk("R1 done", {15'd0, op_done}, 16'd0);
  endtask

  task automatic t_ports;
    port_write(4'd4, 16'h1234);
    port_write(4'd9, 16'hA5A5);
    rd_a_addr = 4'd4; rd_b_addr = 4'd9;
    #1;
    chk("R13 port a", rd_a_data, 16'h1234);
    chk("R13 port b", rd_b_data, 16'hA5A5);
    rd_a_addr = 4'd1;
    #1;
    chk("R13 port a sp", rd_a_data, sp);
    port_write(4'd0, 16'h4567);
    chk("R2 odd pc write", pc, 16'h4566);
    port_write(4'd1, 16'h0301);
    chk("R3 odd sp write", sp, 16'h0300);
    port_write(4'd1, 16'h0200);
  endtask

  task automatic t_advance;
    logic [15:0] p;
    p = pc;
    pc_advance = 1'b1;
    repeat (3) @(negedge clk);
    pc_advance = 1'b0;
    chk("R4 advance x3", pc, p + 16'd6);
    pc_advance = 1'b1;
    port_write(4'd0, 16'h4100);
    pc_advance = 1'b0;
    chk("R4 write beats advance", pc, 16'h4100);
  endtask

  task automatic t_push_pop;
    do_op(2'd0, 16'hBEEF, 4'd0, 2, 16'h01FE, 1'b0, 4'd0, 1'b0);
    chk("R5 sp after push", sp, 16'h01FE);
    chk("R5 mem", mem[8'hFF], 16'hBEEF);
    after_done();
    do_op(2'd0, 16'h1111, 4'd0, 0, 16'h01FC, 1'b0, 4'd0, 1'b0);
    chk("R5 sp no wait", sp, 16'h01FC);
    after_done();
    do_op(2'd1, 16'h0000, 4'd7, 1, 16'h01FC, 1'b0, 4'd0, 1'b0);
    rd_a_addr = 4'd7;
    #1;
    chk("R6 pop data", rd_a_data, 16'h1111);
    chk("R6 sp after pop", sp, 16'h01FE);
    after_done();
  endtask

  task automatic t_call_ret;
    logic [15:0] p;
    p = pc;
    do_op(2'd2, 16'h5001, 4'd0, 1, 16'h01FC, 1'b0, 4'd0, 1'b0);
    chk("R7 pc target even", pc, 16'h5000);
    chk("R7 sp", sp, 16'h01FC);
    chk("R7 saved pc", mem[8'hFE], p);
    after_done();
    do_op(2'd3, 16'h0000, 4'd0, 3, 16'h01FC, 1'b0, 4'd0, 1'b0);
    chk("R8 pc restored", pc, p);
    chk("R8 sp", sp, 16'h01FE);
    after_done();
  endtask

  task automatic t_corners;
    do_op(2'd0, 16'h6003, 4'd0, 0, 16'h01FC, 1'b1, 4'd1, 1'b0);
    chk("R11 push beats sp write", sp, 16'h01FC);
    after_done();
    do_op(2'd3, 16'h0000, 4'd0, 1, 16'h01FC, 1'b1, 4'd0, 1'b0);
    chk("R2 ret odd word", pc, 16'h6002);
    chk("R11 ret beats pc write", pc, 16'h6002);
    chk("R8 sp", sp, 16'h01FE);
    after_done();
    do_op(2'd0, 16'h2222, 4'd0, 2, 16'h01FC, 1'b0, 4'd0, 1'b1);
    chk("R12 sp after ignored request", sp, 16'h01FC);
    after_done();
    chk("R12 pc untouched", pc, 16'h6002);
    port_write(4'd1, 16'h01FE);
    do_op(2'd1, 16'h0000, 4'd1, 1, 16'h01FE, 1'b0, 4'd0, 1'b0);
    chk("R6 pop to sp", sp, 16'h0200);
    after_done();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    @(negedge clk);
    t_ports();
    t_advance();
    t_push_pop();
    t_call_ret();
    t_corners();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd1, 16'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule